// File: doc/BRIEF.md
# Windowed Bus Access Counters

This block keeps performance counters for the two buses that reach external memory through a cache: an instruction bus and a data bus. The cache reports each access as a strobe. The strobe carries the virtual address, whether the access missed, and, on the data bus, whether the target was flash or external RAM. Software programs an address window for each bus, and only strobes whose address falls inside that window are counted.

The instruction side keeps two counters: all accesses and misses. The data side keeps three: all accesses, misses to flash and misses to external RAM. Each counter wraps on overflow and sets its own sticky status bit.

For each bus there is a one-cycle clear pulse that zeroes that bus's counters and status, and an acknowledge pulse that removes that bus's status bits only. The interrupt is raised while any status bit is set whose bus has its interrupt enable high.

Top module: `bus_window_counters`

## Requirements
- R1: After reset every counter reads zero, all five status bits are zero and `irq` is low.
- R2: A strobe is counted only when `win_lo <= addr <= win_hi` for its bus, with both bounds inclusive. When `win_lo > win_hi`, that bus counts nothing.
- R3: Each counted instruction strobe adds one to `ib_acc_cnt`. When `ib_miss` is also high, it adds one to `ib_miss_cnt` as well.
- R4: Each counted data strobe adds one to `db_acc_cnt`. A counted data miss adds one to `db_flash_miss_cnt` when `db_ext` is 0, or to `db_ext_miss_cnt` when `db_ext` is 1.
- R5: A counter that is incremented while holding 2^CNT_W-1 becomes zero, and its status bit is set by that same update.
- R6: The status bits are sticky, at these positions of `ovf_st`: bit 0 is `ib_acc_cnt`, bit 1 is `ib_miss_cnt`, bit 2 is `db_acc_cnt`, bit 3 is `db_flash_miss_cnt`, bit 4 is `db_ext_miss_cnt`.
- R7: A clear pulse on one bus zeroes that bus's counters and status bits at the next edge, even if a strobe arrives in the same cycle. The other bus is not affected.
- R8: An acknowledge pulse on one bus zeroes that bus's status bits and leaves its counters unchanged. If an overflow happens in the same cycle, the overflowing counter's status bit still ends up set.
- R9: `irq` is high exactly when (`ovf_st[1:0]` is nonzero and `ib_irq_en` is high) or (`ovf_st[4:2]` is nonzero and `db_irq_en` is high).
- R10: A strobe, clear or acknowledge sampled at a rising clock edge is visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ib_vld | input | 1 | Instruction bus access strobe |
| ib_addr | input | ADDR_W | Instruction access virtual address |
| ib_miss | input | 1 | Instruction access missed the cache |
| db_vld | input | 1 | Data bus access strobe |
| db_addr | input | ADDR_W | Data access virtual address |
| db_miss | input | 1 | Data access missed the cache |
| db_ext | input | 1 | Data access target: 0 flash, 1 external RAM |
| ib_win_lo | input | ADDR_W | Instruction window start, inclusive |
| ib_win_hi | input | ADDR_W | Instruction window end, inclusive |
| db_win_lo | input | ADDR_W | Data window start, inclusive |
| db_win_hi | input | ADDR_W | Data window end, inclusive |
| ib_clr | input | 1 | Clear pulse for the instruction counters |
| db_clr | input | 1 | Clear pulse for the data counters |
| ib_irq_en | input | 1 | Interrupt enable for the instruction status bits |
| db_irq_en | input | 1 | Interrupt enable for the data status bits |
| ib_irq_ack | input | 1 | Acknowledge pulse for the instruction status bits |
| db_irq_ack | input | 1 | Acknowledge pulse for the data status bits |
| ib_acc_cnt | output | CNT_W | Instruction access count |
| ib_miss_cnt | output | CNT_W | Instruction miss count |
| db_acc_cnt | output | CNT_W | Data access count |
| db_flash_miss_cnt | output | CNT_W | Data miss count, flash target |
| db_ext_miss_cnt | output | CNT_W | Data miss count, external RAM target |
| ovf_st | output | 5 | Sticky overflow status bits |
| irq | output | 1 | Overflow interrupt |

## Verification
Every counter and status bit sits directly on a port. A wrong increment, a misplaced window bound or a miss steered to the wrong target therefore shows as a count mismatch one cycle after the offending strobe. It does not need to accumulate first. A status bit that is lost or set early shows on `ovf_st` in the same cycle as the wrap, and on `irq` once the bus enable is high. A clear or acknowledge that reaches the wrong bus is caught one cycle later, when the other bus's values are compared against their expected state.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  localparam int NUM_CNT     = 5;
  localparam int ST_IB_ACC   = 0;
  localparam int ST_IB_MISS  = 1;
  localparam int ST_DB_ACC   = 2;
  localparam int ST_DB_FMISS = 3;
  localparam int ST_DB_XMISS = 4;
  localparam int IB_NCNT     = 2;
  localparam int DB_NCNT     = 3;
endpackage

// File: rtl/bwc_window.sv
module bwc_window #(
  parameter int ADDR_W = 32
) (
  input  logic              vld,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic              hit
);
  logic above_lo;
  logic below_hi;

  // both bounds inclusive (R2)
  always_comb begin
    above_lo = (addr >= lo);
    below_hi = (addr <= hi);
    hit      = vld & above_lo & below_hi;
  end
endmodule

// File: rtl/bwc_counter.sv
module bwc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic             ack,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             upd_en;

  always_comb begin
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    upd_en = clr | inc | ack;
    if (clr) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else begin
      if (ack) ovf_d = 1'b0;
      if (inc) begin
        cnt_d = cnt_q + ONE;
        if (cnt_q == MAXV) ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;

  a_r7_clr_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0) && !ovf);
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc) |=> cnt == $past(cnt) + ONE);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc && !ack) |=> $stable(cnt) && $stable(ovf));
  a_r5_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(inc) && ($past(cnt) == MAXV));
  a_r8_set_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && cnt == MAXV) |=> ovf);
endmodule

// File: rtl/bwc_side.sv
module bwc_side #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32,
  parameter bit SPLIT_MISS = 1'b0,
  localparam int NCNT      = SPLIT_MISS ? 3 : 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       vld,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       miss,
  input  logic                       tgt,
  input  logic [ADDR_W-1:0]          lo,
  input  logic [ADDR_W-1:0]          hi,
  input  logic                       clr,
  input  logic                       ack,
  output logic [NCNT-1:0][CNT_W-1:0] cnt_o,
  output logic [NCNT-1:0]            ovf_o
);
  logic            hit;
  logic [NCNT-1:0] inc;
  logic [1:0]      miss_idx;

  bwc_window #(.ADDR_W(ADDR_W)) u_win (
    .vld (vld),
    .addr(addr),
    .lo  (lo),
    .hi  (hi),
    .hit (hit)
  );

  // miss counter selection: index 1 flash/only, index 2 external RAM (R4)
  always_comb begin
    miss_idx = 2'd1 + ((SPLIT_MISS && tgt) ? 2'd1 : 2'd0);
    inc[0]   = hit;
    for (int k = 1; k < NCNT; k++) begin
      inc[k] = hit & miss & (miss_idx == 2'(k));
    end
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    bwc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (inc[g]),
      .clr  (clr),
      .ack  (ack),
      .cnt  (cnt_o[g]),
      .ovf  (ovf_o[g])
    );
  end
endmodule

// File: rtl/bus_window_counters.sv
module bus_window_counters
  import bwc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ib_vld,
  input  logic [ADDR_W-1:0] ib_addr,
  input  logic              ib_miss,
  input  logic              db_vld,
  input  logic [ADDR_W-1:0] db_addr,
  input  logic              db_miss,
  input  logic              db_ext,
  input  logic [ADDR_W-1:0] ib_win_lo,
  input  logic [ADDR_W-1:0] ib_win_hi,
  input  logic [ADDR_W-1:0] db_win_lo,
  input  logic [ADDR_W-1:0] db_win_hi,
  input  logic              ib_clr,
  input  logic              db_clr,
  input  logic              ib_irq_en,
  input  logic              db_irq_en,
  input  logic              ib_irq_ack,
  input  logic              db_irq_ack,
  output logic [CNT_W-1:0]  ib_acc_cnt,
  output logic [CNT_W-1:0]  ib_miss_cnt,
  output logic [CNT_W-1:0]  db_acc_cnt,
  output logic [CNT_W-1:0]  db_flash_miss_cnt,
  output logic [CNT_W-1:0]  db_ext_miss_cnt,
  output logic [NUM_CNT-1:0] ovf_st,
  output logic              irq
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [IB_NCNT-1:0][CNT_W-1:0] ib_cnt;
  logic [IB_NCNT-1:0]            ib_ovf;
  logic [DB_NCNT-1:0][CNT_W-1:0] db_cnt;
  logic [DB_NCNT-1:0]            db_ovf;

  bwc_side #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SPLIT_MISS(1'b0)) u_ib (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .vld  (ib_vld),
    .addr (ib_addr),
    .miss (ib_miss),
    .tgt  (1'b0),
    .lo   (ib_win_lo),
    .hi   (ib_win_hi),
    .clr  (ib_clr),
    .ack  (ib_irq_ack),
    .cnt_o(ib_cnt),
    .ovf_o(ib_ovf)
  );

  bwc_side #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SPLIT_MISS(1'b1)) u_db (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .vld  (db_vld),
    .addr (db_addr),
    .miss (db_miss),
    .tgt  (db_ext),
    .lo   (db_win_lo),
    .hi   (db_win_hi),
    .clr  (db_clr),
    .ack  (db_irq_ack),
    .cnt_o(db_cnt),
    .ovf_o(db_ovf)
  );

  always_comb begin
    ib_acc_cnt          = ib_cnt[0];
    ib_miss_cnt         = ib_cnt[1];
    db_acc_cnt          = db_cnt[0];
    db_flash_miss_cnt   = db_cnt[1];
    db_ext_miss_cnt     = db_cnt[2];
    ovf_st              = '0;
    ovf_st[ST_IB_ACC]   = ib_ovf[0];
    ovf_st[ST_IB_MISS]  = ib_ovf[1];
    ovf_st[ST_DB_ACC]   = db_ovf[0];
    ovf_st[ST_DB_FMISS] = db_ovf[1];
    ovf_st[ST_DB_XMISS] = db_ovf[2];
  end

  // interrupt gating per bus (R9)
  logic ib_pend, db_pend;
  always_comb begin
    ib_pend = (|ib_ovf) & ib_irq_en;
    db_pend = (|db_ovf) & db_irq_en;
    irq     = ib_pend | db_pend;
  end

  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!ib_irq_en && !db_irq_en) |-> !irq);
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_sync_q |-> (ovf_st == '0) && (ib_acc_cnt == '0) && (db_acc_cnt == '0));
  a_r2_ib_outside: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!ib_clr && ib_vld && (ib_addr < ib_win_lo || ib_addr > ib_win_hi))
      |=> $stable(ib_acc_cnt) && $stable(ib_miss_cnt));
  a_r2_db_outside: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!db_clr && db_vld && (db_addr < db_win_lo || db_addr > db_win_hi))
      |=> $stable(db_acc_cnt));
  a_r7_side_isolation: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (ib_clr && !db_clr && !db_vld && !db_irq_ack)
      |=> $stable(db_acc_cnt) && $stable(ovf_st[ST_DB_XMISS:ST_DB_ACC]));
  a_r4_target_split: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!db_clr && db_vld && db_miss && db_ext) |=> $stable(db_flash_miss_cnt));
endmodule

// File: tb/bus_window_counters_test.sv
module bus_window_counters_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 4;
  localparam int CW  = 4;
  localparam int MAXC = (1 << CW) - 1;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ib_vld = 0, ib_miss = 0, db_vld = 0, db_miss = 0, db_ext = 0;
  logic [AW-1:0] ib_addr = '0, db_addr = '0;
  logic [AW-1:0] ib_win_lo = '0, ib_win_hi = '0, db_win_lo = '0, db_win_hi = '0;
  logic ib_clr = 0, db_clr = 0, ib_irq_en = 0, db_irq_en = 0, ib_irq_ack = 0, db_irq_ack = 0;
  logic [CW-1:0] ib_acc_cnt, ib_miss_cnt, db_acc_cnt, db_flash_miss_cnt, db_ext_miss_cnt;
  logic [4:0] ovf_st;
  logic irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ecnt [5];
  int est  [5];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_window_counters #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .ib_vld(ib_vld), .ib_addr(ib_addr), .ib_miss(ib_miss),
    .db_vld(db_vld), .db_addr(db_addr), .db_miss(db_miss), .db_ext(db_ext),
    .ib_win_lo(ib_win_lo), .ib_win_hi(ib_win_hi),
    .db_win_lo(db_win_lo), .db_win_hi(db_win_hi),
    .ib_clr(ib_clr), .db_clr(db_clr),
    .ib_irq_en(ib_irq_en), .db_irq_en(db_irq_en),
    .ib_irq_ack(ib_irq_ack), .db_irq_ack(db_irq_ack),
    .ib_acc_cnt(ib_acc_cnt), .ib_miss_cnt(ib_miss_cnt),
    .db_acc_cnt(db_acc_cnt), .db_flash_miss_cnt(db_flash_miss_cnt),
    .db_ext_miss_cnt(db_ext_miss_cnt), .ovf_st(ovf_st), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // count one event of counter k: wrap and set status (R5)
  task automatic bump(input int k);
    if (ecnt[k] == MAXC) begin
      ecnt[k] = 0;
      est[k]  = 1;
    end else begin
      ecnt[k] = ecnt[k] + 1;
    end
  endtask

  task automatic model_step();
    bit ib_in, db_in;
    ib_in = ib_vld && (ib_addr >= ib_win_lo) && (ib_addr <= ib_win_hi);
    db_in = db_vld && (db_addr >= db_win_lo) && (db_addr <= db_win_hi);
    if (ib_clr) begin
      for (int k = 0; k < 2; k++) begin ecnt[k] = 0; est[k] = 0; end
    end else begin
      if (ib_irq_ack) begin est[0] = 0; est[1] = 0; end
      if (ib_in) bump(0);
      if (ib_in && ib_miss) bump(1);
    end
    if (db_clr) begin
      for (int k = 2; k < 5; k++) begin ecnt[k] = 0; est[k] = 0; end
    end else begin
      if (db_irq_ack) begin est[2] = 0; est[3] = 0; est[4] = 0; end
      if (db_in) bump(2);
      if (db_in && db_miss && !db_ext) bump(3);
      if (db_in && db_miss && db_ext) bump(4);
    end
  endtask

  task automatic compare(input string tag);
    int st_exp, irq_exp;
    st_exp = est[0] | (est[1] << 1) | (est[2] << 2) | (est[3] << 3) | (est[4] << 4);
    irq_exp = ((est[0] | est[1]) & ib_irq_en) | ((est[2] | est[3] | est[4]) & db_irq_en);
    chk({tag, " R3 ib_acc_cnt"}, ib_acc_cnt, ecnt[0]);
    chk({tag, " R3 ib_miss_cnt"}, ib_miss_cnt, ecnt[1]);
    chk({tag, " R4 db_acc_cnt"}, db_acc_cnt, ecnt[2]);
    chk({tag, " R4 db_flash_miss_cnt"}, db_flash_miss_cnt, ecnt[3]);
    chk({tag, " R4 db_ext_miss_cnt"}, db_ext_miss_cnt, ecnt[4]);
    chk({tag, " R6 ovf_st"}, ovf_st, st_exp);
    chk({tag, " R9 irq"}, irq, irq_exp);
  endtask

  // inputs set at negedge; model then edge; compare just after edge (R10)
  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    #1;
    compare(tag);
    @(negedge clk);
    ib_vld = 0; db_vld = 0; ib_clr = 0; db_clr = 0; ib_irq_ack = 0; db_irq_ack = 0;
  endtask

  initial begin
    for (int k = 0; k < 5; k++) begin ecnt[k] = 0; est[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    compare("R1 reset");

    // R2/R3/R4/R5/R6/R9: sweep of windows and addresses
    for (int lo = 0; lo < 16; lo++) begin
      for (int hi = 0; hi < 16; hi++) begin
        for (int a = 0; a < 16; a++) begin
          ib_win_lo = AW'(lo); ib_win_hi = AW'(hi);
          db_win_lo = AW'(hi); db_win_hi = AW'(lo);
          ib_irq_en = hi[0]; db_irq_en = lo[1];
          ib_vld = 1; ib_addr = AW'(a); ib_miss = a[0] ^ lo[0];
          db_vld = ((a + hi) % 3) != 0; db_addr = AW'(15 - a);
          db_miss = a[1]; db_ext = a[2] ^ hi[1];
          ib_irq_ack = (a == 7) && lo[0];
          db_irq_ack = (a == 9) && hi[2];
          db_clr = (a == 0) && (hi == lo);
          tick("R2 sweep");
        end
      end
    end

    // R7: clear with a simultaneous in-window strobe, other side kept
    ib_win_lo = 0; ib_win_hi = 15; db_win_lo = 0; db_win_hi = 15;
    ib_irq_en = 1; db_irq_en = 1;
    for (int i = 0; i < 5; i++) begin
      ib_vld = 1; ib_addr = 4'd3; ib_miss = 1;
      db_vld = 1; db_addr = 4'd5; db_miss = 1; db_ext = i[0];
      tick("R7 prefill");
    end
    ib_vld = 1; ib_miss = 1; ib_clr = 1; ib_addr = 4'd2;
    db_vld = 1; db_miss = 0; db_addr = 4'd2;
    tick("R7 clear priority");
    chk("R7 ib_acc_cnt zero after clear", ib_acc_cnt, 0);
    db_clr = 1;
    tick("R7 db clear");
    chk("R7 db_acc_cnt zero after clear", db_acc_cnt, 0);

    // R5/R8: overflow in the same cycle as acknowledge
    for (int i = 0; i < MAXC; i++) begin
      ib_vld = 1; ib_addr = 4'd15; ib_miss = 0;
      tick("R5 fill");
    end
    chk("R5 ib_acc_cnt at max", ib_acc_cnt, MAXC);
    ib_vld = 1; ib_addr = 4'd0; ib_irq_ack = 1;
    tick("R8 set beats ack");
    chk("R5 wrap to zero", ib_acc_cnt, 0);
    chk("R8 status kept", ovf_st[0], 1);
    chk("R9 irq raised", irq, 1);
    ib_irq_en = 0;
    tick("R9 enable low");
    chk("R9 irq masked", irq, 0);
    ib_irq_ack = 1;
    tick("R8 ack clears");
    chk("R8 ack keeps counter", ib_acc_cnt, 0);
    chk("R8 status cleared", ovf_st, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    errors++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule